// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block turns single-byte bus requests into correctly timed strobe waveforms on an asynchronous NAND flash interface. It drives chip-enable, write-enable, read-enable and the data bus drive enable from a system clock. All phase lengths come from one 32-bit timing word, counted in clock cycles.

The timing word sets the low and high time of each strobe as cumulative edge counts. It also sets a turnaround after reads, a wait before the ready/busy line is trusted, and a lead time for chip-enable ahead of a read strobe. The timing word is guarded by a single-use key written to a separate lock register.

A client issues one of three operations on a valid/ready port: a byte write, a byte read, or a wait for the flash to report ready. It receives a one-cycle acknowledge when the operation is complete. Command and address sequencing are left to the client.

Top module: `nand_strobe_gen`

## Requirements
- R1: The timing word is written with `cfg_sel`=1 and read back on `cur_timing`. Its fields are: write-low count in bits 3:0, write-high count in bits 7:4, read-low count in bits 11:8, read-high count in bits 15:12, read turnaround in bits 18:16, busy delay in bits 23:19 and chip-enable lead in bits 25:24. Bits 31:26 are not stored and read as zero.
- R2: In a write (`req_op`=0), `nand_we_n` is low for write-low+1 cycles starting the cycle after acceptance. It then stays high for write-high minus write-low cycles, after which `req_ack` pulses.
- R3: In a read (`req_op`=1), `nand_re_n` is low for read-low+1 cycles. It is then high for read-high minus read-low cycles plus the turnaround count before `req_ack` pulses.
- R4: When a high count is not greater than its low count, the high phase lasts exactly one cycle (before any turnaround is added).
- R5: A read begins with a lead of chip-enable-lead cycles in which `nand_ce_n` is low and `nand_re_n` is high. `nand_ce_n` stays low for the whole read or write.
- R6: The read byte on `rsp_rdata` is the value `nand_din` held during the last cycle of the read-enable low phase. It stays on `rsp_rdata` until the next read.
- R7: In a wait-ready (`req_op[1]`=1), the block first lets the busy-delay count of cycles pass, then samples `nand_rb` once per cycle. `req_ack` pulses the cycle after the first high sample.
- R8: `req_ready` is low from the cycle after acceptance until the acknowledge cycle, in which it is high again. `req_ack` is never high for two cycles in a row.
- R9: A timing-word write takes effect only if the write to the lock register (`cfg_sel`=0) just before it carried 0xA25E in bits 15:0. Any timing-word write consumes the unlock, and a lock write of any other value clears it.
- R10: After reset, all strobes and `nand_ce_n` are high, `nand_doe` is low, `req_ready` is high and every timing field is zero.
- R11: The data bus is driven (`nand_doe`=1, `nand_dout` = write byte) only during a write's low and high phases, never while `nand_re_n` is low.
- R12: `nand_we_n` and `nand_re_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = lock register, 1 = timing word |
| cfg_wdata | input | 32 | Configuration write data |
| cur_timing | output | 32 | Current timing word |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 0 write, 1 read, 2 or 3 wait-ready |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block idle, request accepted when high |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dout | output | 8 | Data bus output |
| nand_doe | output | 1 | Data bus output enable |
| nand_din | input | 8 | Data bus input |
| nand_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The assertions assume that the timing word and the lock register are written only while the block is idle. They also assume that a request is held no longer than its accepting cycle. The bench meets both conditions: it reprograms timing only between operations and drops `req_valid` on the falling edge right after acceptance. It drives `nand_din` and `nand_rb` only on falling edges, changing `nand_din` every cycle so that the capture cycle can be identified, and raising `nand_rb` at a randomly chosen cycle that may fall before or after the busy delay expires.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  localparam int TW_BITS = 26;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLOW,
    ST_WHIGH,
    ST_CEA,
    ST_RLOW,
    ST_RHIGH,
    ST_BDLY,
    ST_POLL
  } nsg_state_e;

  typedef struct packed {
    logic [1:0] tcea;
    logic [4:0] busy;
    logic [2:0] ta;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } nsg_timing_t;

  function automatic nsg_timing_t unpack_timing(input logic [31:0] w);
    nsg_timing_t t;
    t.wr_lo = w[3:0];
    t.wr_hi = w[7:4];
    t.rd_lo = w[11:8];
    t.rd_hi = w[15:12];
    t.ta    = w[18:16];
    t.busy  = w[23:19];
    t.tcea  = w[25:24];
    return t;
  endfunction

endpackage

// File: rtl/nsg_cfg_regs.sv
module nsg_cfg_regs
  import nsg_pkg::*;
#(
  parameter logic [15:0] UNLOCK_KEY = 16'hA25E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] timing_word,
  output logic        unlocked
);

  logic [TW_BITS-1:0] word_q, word_d;
  logic               unlock_q, unlock_d;
  logic               word_en;

  always_comb begin
    unlock_d = unlock_q;
    word_d   = word_q;
    word_en  = 1'b0;
    if (cfg_wr) begin
      if (cfg_sel) begin
        word_en  = unlock_q;
        word_d   = cfg_wdata[TW_BITS-1:0];
        unlock_d = 1'b0;
      end else begin
        unlock_d = (cfg_wdata[15:0] == UNLOCK_KEY);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign timing_word = {{(32-TW_BITS){1'b0}}, word_q};
  assign unlocked    = unlock_q;

endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
  import nsg_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  nsg_timing_t tim,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        nand_rb,
  output nsg_state_e  state_q,
  output nsg_state_e  state_d,
  output logic        done,
  output logic        cap_en
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;
  logic [CNT_W-1:0] wr_hi_len, rd_hi_len;

  assign cnt_zero = (cnt_q == '0);

  // high phase length: difference of cumulative counts, floored at one cycle
  assign wr_hi_len = (tim.wr_hi > tim.wr_lo) ? CNT_W'(tim.wr_hi - tim.wr_lo) : CNT_W'(1);
  assign rd_hi_len = (tim.rd_hi > tim.rd_lo) ? CNT_W'(tim.rd_hi - tim.rd_lo) : CNT_W'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q - CNT_W'(1);
    cnt_en  = 1'b1;
    done    = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_en = 1'b0;
        if (req_valid) begin
          cnt_en = 1'b1;
          if (req_op[1]) begin
            if (tim.busy != '0) begin
              state_d = ST_BDLY;
              cnt_d   = CNT_W'(tim.busy) - CNT_W'(1);
            end else begin
              state_d = ST_POLL;
              cnt_d   = '0;
            end
          end else if (req_op == OP_READ) begin
            if (tim.tcea != '0) begin
              state_d = ST_CEA;
              cnt_d   = CNT_W'(tim.tcea) - CNT_W'(1);
            end else begin
              state_d = ST_RLOW;
              cnt_d   = CNT_W'(tim.rd_lo);
            end
          end else begin
            state_d = ST_WLOW;
            cnt_d   = CNT_W'(tim.wr_lo);
          end
        end
      end
      ST_WLOW: begin
        if (cnt_zero) begin
          state_d = ST_WHIGH;
          cnt_d   = wr_hi_len - CNT_W'(1);
        end
      end
      ST_WHIGH: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          done    = 1'b1;
          cnt_en  = 1'b0;
        end
      end
      ST_CEA: begin
        if (cnt_zero) begin
          state_d = ST_RLOW;
          cnt_d   = CNT_W'(tim.rd_lo);
        end
      end
      ST_RLOW: begin
        if (cnt_zero) begin
          state_d = ST_RHIGH;
          cap_en  = 1'b1;
          cnt_d   = rd_hi_len + CNT_W'(tim.ta) - CNT_W'(1);
        end
      end
      ST_RHIGH: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          done    = 1'b1;
          cnt_en  = 1'b0;
        end
      end
      ST_BDLY: begin
        if (cnt_zero) begin
          state_d = ST_POLL;
          cnt_en  = 1'b0;
        end
      end
      ST_POLL: begin
        cnt_en = 1'b0;
        if (nand_rb) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nsg_pins.sv
module nsg_pins
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nsg_state_e        state_q,
  input  nsg_state_e        state_d,
  input  logic              done,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] nand_din,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic              doe,
  output logic [DATA_W-1:0] dout,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);

  logic ce_d, we_d, re_d, doe_d;
  logic dout_en;

  always_comb begin
    we_d    = (state_d == ST_WLOW);
    re_d    = (state_d == ST_RLOW);
    doe_d   = (state_d == ST_WLOW) || (state_d == ST_WHIGH);
    ce_d    = doe_d || (state_d == ST_CEA) || (state_d == ST_RLOW) ||
              (state_d == ST_RHIGH);
    dout_en = (state_q == ST_IDLE) && (state_d == ST_WLOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n <= 1'b1;
      we_n <= 1'b1;
      re_n <= 1'b1;
      doe  <= 1'b0;
      ack  <= 1'b0;
    end else begin
      ce_n <= !ce_d;
      we_n <= !we_d;
      re_n <= !re_d;
      doe  <= doe_d;
      ack  <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (dout_en) begin
      dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= nand_din;
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 6,
  parameter logic [15:0] UNLOCK_KEY = 16'hA25E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cur_timing,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_doe,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb
);

  nsg_state_e  state_q, state_d;
  logic        done, cap_en;
  logic        unlocked;
  nsg_timing_t tim;

  nsg_cfg_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .timing_word (cur_timing),
    .unlocked    (unlocked)
  );

  assign tim = unpack_timing(cur_timing);

  nsg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tim       (tim),
    .req_valid (req_valid),
    .req_op    (req_op),
    .nand_rb   (nand_rb),
    .state_q   (state_q),
    .state_d   (state_d),
    .done      (done),
    .cap_en    (cap_en)
  );

  assign req_ready = (state_q == ST_IDLE);

  nsg_pins #(.DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .state_d   (state_d),
    .done      (done),
    .cap_en    (cap_en),
    .req_wdata (req_wdata),
    .nand_din  (nand_din),
    .ce_n      (nand_ce_n),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .doe       (nand_doe),
    .dout      (nand_dout),
    .ack       (req_ack),
    .rdata     (rsp_rdata)
  );

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_ce_n,
  input logic        nand_doe,
  input logic        req_ack,
  input logic        req_ready,
  input logic        cfg_wr,
  input logic        cfg_sel,
  input logic [31:0] cur_timing,
  input logic        unlocked
);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_no_drive_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_doe);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !req_ready);

  assert_ack_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> req_ready);

  assert_ce_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_lock_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_timing != $past(cur_timing)) |-> $past(cfg_wr && cfg_sel && unlocked));

  assert_unused_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_timing[31:26] == 6'd0);

endmodule

bind nand_strobe_gen nsg_checker u_chk (.*);

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cur_timing;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        req_ack;
  logic [7:0]  rsp_rdata;
  logic        nand_ce_n, nand_we_n, nand_re_n, nand_doe;
  logic [7:0]  nand_dout;
  logic [7:0]  nand_din;
  logic        nand_rb;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model_tw;
  logic        model_unlock;
  logic        finished = 1'b0;

  nand_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cur_timing(cur_timing), .req_valid(req_valid),
    .req_op(req_op), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
    .nand_doe(nand_doe), .nand_din(nand_din), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hi_len(input int lo, input int hi);
    return (hi > lo) ? hi - lo : 1;
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel) begin
      if (model_unlock) model_tw = {6'd0, d[25:0]};
      model_unlock = 1'b0;
    end else begin
      model_unlock = (d[15:0] == 16'hA25E);
    end
  endtask

  task automatic set_timing(input logic [31:0] d);
    cfg_write(1'b0, 32'h0000A25E);
    cfg_write(1'b1, d);
    check(cur_timing == model_tw, "R1 timing readback", cur_timing, model_tw);
  endtask

  // runs one operation; rb_at = cycle index at which ready/busy rises
  task automatic run_op(input logic [1:0] op, input logic [7:0] wd,
                        input int rb_at, input logic [7:0] din_base);
    int wl = model_tw[3:0];
    int wh = model_tw[7:4];
    int rl = model_tw[11:8];
    int rh = model_tw[15:12];
    int ta = model_tw[18:16];
    int bd = model_tw[23:19];
    int ce = model_tw[25:24];
    int we_low = 0, re_low = 0, lead = 0, pre = 0, drv = 0;
    bit seen_re = 0, ready_ok = 1, dout_ok = 1, both_low = 0, ack_seen = 0;
    @(negedge clk);
    if (op[1]) nand_rb = 1'b0;
    req_valid = 1'b1; req_op = op; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (req_ack) begin
        ack_seen = 1;
        check(req_ready && nand_we_n && nand_re_n, "R8 ready at ack", req_ready, 1);
        break;
      end
      pre++;
      if (req_ready) ready_ok = 0;
      if (!nand_we_n) we_low++;
      if (!nand_re_n) begin re_low++; seen_re = 1; end
      if (!nand_we_n && !nand_re_n) both_low = 1;
      if (!seen_re && !nand_ce_n && nand_re_n && op == 2'd1) lead++;
      if (nand_doe) begin
        drv++;
        if (nand_dout != wd) dout_ok = 0;
      end
      nand_din = din_base ^ 8'(i);
      if (op[1] && i >= rb_at) nand_rb = 1'b1;
      @(negedge clk);
    end
    check(ack_seen, "R8 ack reached", ack_seen, 1);
    check(ready_ok, "R8 ready low while busy", ready_ok, 1);
    check(!both_low, "R12 strobes exclusive", both_low, 0);
    if (op == 2'd0) begin
      check(we_low == wl + 1, "R2 we low length", we_low, wl + 1);
      check(pre == wl + 1 + hi_len(wl, wh), "R2/R4 write total", pre, wl + 1 + hi_len(wl, wh));
      check(drv == pre && dout_ok, "R11 write drive", drv, pre);
    end else if (op == 2'd1) begin
      check(re_low == rl + 1, "R3 re low length", re_low, rl + 1);
      check(lead == ce, "R5 ce lead", lead, ce);
      check(pre == ce + rl + 1 + hi_len(rl, rh) + ta, "R3/R4 read total",
            pre, ce + rl + 1 + hi_len(rl, rh) + ta);
      check(drv == 0, "R11 no drive in read", drv, 0);
      check(rsp_rdata == (din_base ^ 8'(ce + rl)), "R6 capture",
            rsp_rdata, din_base ^ 8'(ce + rl));
    end else begin
      check(pre == ((bd > rb_at) ? bd : rb_at) + 1, "R7 wait length",
            pre, ((bd > rb_at) ? bd : rb_at) + 1);
      check(we_low == 0 && re_low == 0, "R7 no strobes", we_low + re_low, 0);
    end
  endtask

  initial begin
    int seed;
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
    seed = 0;
  end

  initial begin
    logic [7:0] saved_rd;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_op = '0; req_wdata = '0; nand_din = '0; nand_rb = 1'b1;
    model_tw = '0; model_unlock = 1'b0;
    repeat (3) @(negedge clk);
    check(nand_we_n && nand_re_n && nand_ce_n && !nand_doe, "R10 strobes idle in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_timing == 32'd0, "R10 timing zero", cur_timing, 0);
    check(req_ready && !req_ack, "R10 ready after reset", req_ready, 1);

    // zero timing: one-cycle low, floored one-cycle high
    run_op(2'd0, 8'h5A, 0, 8'h00);
    run_op(2'd1, 8'h00, 0, 8'h3C);

    // R9: write without unlock is ignored
    cfg_write(1'b1, 32'h0012_3456);
    check(cur_timing == 32'd0, "R9 locked write ignored", cur_timing, 0);
    // R9: unlock then write takes effect; bits 31:26 dropped (R1)
    cfg_write(1'b0, 32'h0000A25E);
    cfg_write(1'b1, 32'hFFFF_FFFF);
    check(cur_timing == 32'h03FF_FFFF, "R1 upper bits dropped", cur_timing, 32'h03FF_FFFF);
    // R9: single use
    cfg_write(1'b1, 32'h0000_0011);
    check(cur_timing == 32'h03FF_FFFF, "R9 unlock single use", cur_timing, 32'h03FF_FFFF);
    // R9: other lock value clears
    cfg_write(1'b0, 32'h0000A25E);
    cfg_write(1'b0, 32'h0000A25F);
    cfg_write(1'b1, 32'h0000_0022);
    check(cur_timing == 32'h03FF_FFFF, "R9 wrong key clears", cur_timing, 32'h03FF_FFFF);
    model_tw = 32'h03FF_FFFF;

    // full-scale values
    run_op(2'd0, 8'hA5, 0, 8'h00);
    run_op(2'd1, 8'h00, 0, 8'h81);
    run_op(2'd2, 8'h00, 3, 8'h00);
    run_op(2'd3, 8'h00, 40, 8'h00);

    // R4 floor: high below low
    set_timing({2'd0, 5'd0, 3'd2, 4'd1, 4'd9, 4'd2, 4'd7});
    run_op(2'd0, 8'h11, 0, 8'h00);
    saved_rd = 8'h00;
    run_op(2'd1, 8'h00, 0, 8'h47);
    // R6: write does not disturb held read byte
    saved_rd = rsp_rdata;
    run_op(2'd0, 8'h22, 0, 8'h00);
    check(rsp_rdata == saved_rd, "R6 read byte held", rsp_rdata, saved_rd);
    // R7: busy delay zero, ready already high
    run_op(2'd2, 8'h00, 0, 8'h00);

    // constrained random
    for (int k = 0; k < 60; k++) begin
      if (k % 4 == 0) set_timing($urandom);
      run_op(2'($urandom_range(0, 3)), 8'($urandom), $urandom_range(0, 40), 8'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule